// File: doc/BRIEF.md
# Four-Bit Shift Register with JK Entry Stage

This block is a small register, clocked on the rising edge, with two modes of operation. In shift mode, every stage passes its bit one place toward the last stage. The first stage takes its new value from a JK-style serial entry, where the K input is active low. That entry can set, clear, invert or keep the first bit while the other stages shift. In load mode, all stages take a parallel word in a single edge.

A mode select input chooses between the two modes. An active-low master reset clears the register at once, without waiting for the clock. Besides the parallel outputs, the block drives the complement of its last stage, so a downstream consumer can use either polarity of the serial stream. Tying the J and K-bar inputs together turns the first stage into a plain D entry.

Internally the mode select picks one of two modes: LOAD or SHIFT. In SHIFT mode, the {J, K-bar} pair selects one of four entry actions: CLEAR, HOLD, TOGGLE or SET.

- On every qualifying rising edge, a transition into LOAD or SHIFT happens according to the mode select.
- Whenever reset is low, every mode gives way to the cleared state.

Top module: `jk_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and `q_last_n` is 1. This takes effect as soon as `rst_n` falls, with no clock edge needed, whatever the other inputs are.
- R2: `q` changes only on a rising edge of `clk`. Input changes between edges leave `q` unchanged.
- R3: With `shift_en` = 1, each edge moves `q[i]` into `q[i+1]` for i from 0 to WIDTH-2. `q[0]` is the first stage and `q[WIDTH-1]` is the last stage.
- R4: In shift mode with `j_in` = 1 and `k_n_in` = 1 (SET), the new `q[0]` is 1.
- R5: In shift mode with `j_in` = 0 and `k_n_in` = 0 (CLEAR), the new `q[0]` is 0.
- R6: In shift mode with `j_in` = 1 and `k_n_in` = 0 (TOGGLE), the new `q[0]` is the inverse of the old `q[0]`.
- R7: In shift mode with `j_in` = 0 and `k_n_in` = 1 (HOLD), the new `q[0]` equals the old `q[0]`.
- R8: With `shift_en` = 0, each edge loads `par_d[i]` into `q[i]` for every i, and `j_in` and `k_n_in` have no effect.
- R9: `q_last_n` is always the complement of `q[WIDTH-1]`.
- R10: When `j_in` and `k_n_in` are driven with the same value b, shift mode enters b into `q[0]`.
- R11: After `rst_n` rises, `q` stays all zeros until the next rising edge, which then applies the selected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_en | input | 1 | 1 = shift mode, 0 = parallel load |
| j_in | input | 1 | J input of the entry stage |
| k_n_in | input | 1 | Active-low K input of the entry stage |
| par_d | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents, q[0] is the first stage |
| q_last_n | output | 1 | Complement of q[WIDTH-1] |

## Verification
The clocked properties assume three things about the inputs:
- the mode select, J, K-bar and the parallel word are stable at each rising edge;
- reset is synchronous to no particular clock phase;
- any edge during which reset is low, or a reset pulse that falls between two edges, discards the check for that edge.

The stimulus meets these assumptions in the following way:
- It changes the data and control inputs only at falling edges, or in the middle of the low clock phase.
- It asserts and releases reset away from rising edges.
- It moves inputs between edges only in the test that shows those changes have no effect.

// File: rtl/jk_shift_reg_pkg.sv
package jk_shift_reg_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } reg_mode_e;

    typedef enum logic [1:0] {
        ENT_CLEAR  = 2'b00,
        ENT_HOLD   = 2'b01,
        ENT_TOGGLE = 2'b10,
        ENT_SET    = 2'b11
    } entry_act_e;

endpackage

// File: rtl/jk_mode_decode.sv
module jk_mode_decode
    import jk_shift_reg_pkg::*;
(
    input  logic       shift_en,
    input  logic       j_in,
    input  logic       k_n_in,
    output reg_mode_e  mode,
    output entry_act_e act
);

    always_comb begin
        mode = shift_en ? MODE_SHIFT : MODE_LOAD;
    end

    // {J, K-bar} picks the action for the first stage
    always_comb begin
        unique case ({j_in, k_n_in})
            2'b00:   act = ENT_CLEAR;
            2'b01:   act = ENT_HOLD;
            2'b10:   act = ENT_TOGGLE;
            2'b11:   act = ENT_SET;
            default: act = ENT_HOLD;
        endcase
    end

endmodule

// File: rtl/jk_entry_stage.sv
module jk_entry_stage
    import jk_shift_reg_pkg::*;
(
    input  entry_act_e act,
    input  logic       cur_bit,
    output logic       next_bit
);

    always_comb begin
        unique case (act)
            ENT_CLEAR:  next_bit = 1'b0;
            ENT_HOLD:   next_bit = cur_bit;
            ENT_TOGGLE: next_bit = ~cur_bit;
            ENT_SET:    next_bit = 1'b1;
            default:    next_bit = cur_bit;
        endcase
    end

endmodule

// File: rtl/jk_stage_chain.sv
module jk_stage_chain
    import jk_shift_reg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_mode_e        mode,
    input  logic             entry_bit,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb begin
                    unique case (mode)
                        MODE_LOAD:  nxt[i] = par_d[i];
                        MODE_SHIFT: nxt[i] = entry_bit;
                        default:    nxt[i] = q[i];
                    endcase
                end
            end else begin : g_rest
                always_comb begin
                    unique case (mode)
                        MODE_LOAD:  nxt[i] = par_d[i];
                        MODE_SHIFT: nxt[i] = q[i-1];
                        default:    nxt[i] = q[i];
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (q == '0);
        end
    end

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHIFT) |=> (q[LAST:1] == $past(q[LAST-1:0])));

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
    import jk_shift_reg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             j_in,
    input  logic             k_n_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_last_n
);

    localparam int LAST = WIDTH - 1;

    reg_mode_e  mode;
    entry_act_e act;
    logic       entry_bit;

    jk_mode_decode u_dec (
        .shift_en (shift_en),
        .j_in     (j_in),
        .k_n_in   (k_n_in),
        .mode     (mode),
        .act      (act)
    );

    jk_entry_stage u_entry (
        .act      (act),
        .cur_bit  (q[0]),
        .next_bit (entry_bit)
    );

    jk_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .entry_bit (entry_bit),
        .par_d     (par_d),
        .q         (q)
    );

    always_comb begin
        q_last_n = ~q[LAST];
    end

    // R4
    entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && j_in && k_n_in) |=> q[0]);

    // R5
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !j_in && !k_n_in) |=> !q[0]);

    // R6
    entry_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && j_in && !k_n_in) |=> (q[0] != $past(q[0])));

    // R7
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !j_in && k_n_in) |=> $stable(q[0]));

    // R8
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> (q == $past(par_d)));

endmodule

// File: tb/jk_shift_reg_bench.sv
module jk_shift_reg_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         j_in = 1'b0;
    logic         k_n_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] mdl = '0;

    always #10 clk = ~clk;

    jk_shift_reg #(.WIDTH(W)) u_jk_shift_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .j_in     (j_in),
        .k_n_in   (k_n_in),
        .par_d    (par_d),
        .q        (q),
        .q_last_n (q_last_n)
    );

    task automatic chk(input string req, input logic [W-1:0] exp);
        n_tests++;
        if (q !== exp || q_last_n !== ~exp[W-1]) begin
            n_fail++;
            $display("FAIL %s: q=%b q_last_n=%b expected q=%b q_last_n=%b",
                     req, q, q_last_n, exp, ~exp[W-1]);
        end
    endtask

    // drive at falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic se, input logic j, input logic kn,
                        input logic [W-1:0] d, input string req);
        shift_en = se; j_in = j; k_n_in = kn; par_d = d;
        @(posedge clk);
        if (!se) mdl = d;
        else begin
            logic b0;
            case ({j, kn})
                2'b00: b0 = 1'b0;
                2'b01: b0 = mdl[0];
                2'b10: b0 = ~mdl[0];
                default: b0 = 1'b1;
            endcase
            mdl = {mdl[W-2:0], b0};
        end
        @(negedge clk);
        chk(req, mdl);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset state", '0);
        rst_n = 1'b1;
        #2 chk("R11 zeros after release", '0);
        @(negedge clk);
        mdl = '0;
    endtask

    task automatic t_load;
        step(1'b0, 1'b1, 1'b0, 4'b1010, "R8 load ignores JK");
        step(1'b0, 1'b0, 1'b1, 4'b0111, "R8 load word 0111");
        step(1'b0, 1'b1, 1'b1, 4'b1000, "R9 last stage high");
    endtask

    task automatic t_entry;
        step(1'b0, 1'b0, 1'b0, 4'b0000, "R8 load zero");
        step(1'b1, 1'b1, 1'b1, 4'b1111, "R4 set");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R6 toggle 1->0");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R6 toggle 0->1");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R7 hold 1");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R7 hold again");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R5 clear");
        step(1'b1, 1'b0, 1'b1, 4'b1111, "R7 hold 0");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R3 shift chain");
    endtask

    task automatic t_dtie;
        logic [7:0] pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++)
            step(1'b1, pat[i], pat[i], 4'b0101, "R10 tied D entry");
    endtask

    task automatic t_between_edges;
        step(1'b0, 1'b0, 1'b0, 4'b1001, "R8 preload");
        par_d = 4'b0110; shift_en = 1'b0; j_in = 1'b1; k_n_in = 1'b0;
        #3 chk("R2 no change between edges", mdl);
        shift_en = 1'b1;
        #3 chk("R2 mode change between edges", mdl);
        @(negedge clk);
    endtask

    task automatic t_async_mid;
        step(1'b0, 1'b0, 1'b0, 4'b1111, "R8 load ones");
        #4 rst_n = 1'b0;
        #1 chk("R1 async clear mid-cycle", '0);
        shift_en = 1'b0; par_d = 4'b1111;
        @(negedge clk);
        chk("R1 clear held across edge", '0);
        mdl = '0;
        #3 rst_n = 1'b1;
        #2 chk("R11 hold zeros until edge", '0);
        @(negedge clk);
        mdl = 4'b1111;
        chk("R11 first edge loads", mdl);
    endtask

    initial begin
        t_reset();
        t_load();
        t_entry();
        t_dtie();
        t_between_edges();
        t_async_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule